// File: doc/BRIEF.md
# I2C Target with Conditional Acknowledge

This block is the target side of a two-wire serial bus with a fixed 7-bit device address. It filters and synchronises both bus lines into the system clock domain. It recognises start, stop and repeated-start conditions and shifts in the address byte and any data bytes. Whether it acknowledges on the ninth clock depends on its own state.

Two inputs from the user logic control that decision. While `busy_i` is high, the target declines its own address. While `rx_full_i` is high at the end of a received byte, it declines that byte and then ignores the bus until the next stop or repeated start. In a read, the target sends bytes supplied on `tx_data_i` after a request pulse. It stops sending as soon as the master declines a byte.

The data line is open-drain. The block only ever asks for the line to be pulled low (`sda_oe_o` high) or leaves it released.

Top module: `i2c_cond_ack_target`

## Requirements
- R1: After a start, when bits 7..1 of the first byte equal `OWN_ADDR` and `busy_i` is low, the target holds SDA low for the whole high phase of the ninth clock.
- R2: When `busy_i` is high at the end of a matching address byte, SDA stays high on the ninth clock, and no later byte is acknowledged until the next start or repeated start.
- R3: An address byte whose bits 7..1 differ from `OWN_ADDR` gets no acknowledge, and the following bytes are not acknowledged or delivered.
- R4: In a write (address bit 0 = 0), each accepted data byte, received MSB first, is acknowledged and appears on `rx_data_o` with a single-cycle `rx_valid_o` pulse.
- R5: When `rx_full_i` is high at the end of a data byte, that byte is not acknowledged and not delivered. Every later byte up to the next stop or repeated start is also refused.
- R6: In a read (address bit 0 = 1), an acknowledged address gives one `tx_req_o` pulse. The byte on `tx_data_i` is then taken at the SCL fall that ends the ninth clock and sent MSB first.
- R7: During the ninth clock of a sent byte the target releases SDA. When it samples a low level there (master ACK), it pulses `tx_req_o` once and sends the next byte.
- R8: When the target samples a high level on the ninth clock (master NACK), it stops driving SDA, raises no further `tx_req_o`, and leaves SDA high for all clocks until a stop or repeated start.
- R9: A repeated start in any state returns the target to address reception with the bit count cleared, so the next byte is taken as an address.
- R10: `sda_oe_o` changes only while SCL is low.
- R11: After reset, `sda_oe_o`, `rx_valid_o` and `tx_req_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |
| busy_i | input | 1 | Decline own address when high |
| rx_full_i | input | 1 | Decline the data byte ending now when high |
| rx_valid_o | output | 1 | One-cycle pulse: received byte valid |
| rx_data_o | output | 8 | Received data byte |
| tx_req_o | output | 1 | One-cycle pulse: supply the next byte to send |
| tx_data_i | input | 8 | Byte to send, taken at the next SCL fall |

## Verification
The hardest situations to reach from the ports are the ones that come after a refusal. These are a busy NACK followed by more bytes, a full NACK in the middle of a write, and a master NACK followed by further clocks with no stop. In all of them the target must stay silent until a start condition.

The bench reaches these situations with a master model that keeps clocking after each refusal. It then issues a repeated start mid-byte or after a hold-off and checks that address reception restarts cleanly. Random transactions vary the address match, the direction, `busy_i`, the byte in which `rx_full_i` rises and the byte count.

// File: rtl/i2c_tgt_pkg.sv
`timescale 1ns/1ps
package i2c_tgt_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_RX,
    ST_RX_ACK,
    ST_TX,
    ST_TX_ACK,
    ST_HOLD_OFF
  } tgt_state_e;

  // Address byte carries the device address in bits 7..1
  function automatic logic addr_hit(input logic [7:0] byte_v, input logic [6:0] own);
    return byte_v[7:1] == own;
  endfunction

  // The target acknowledges its address only when not busy
  function automatic logic addr_accept(input logic [7:0] byte_v, input logic [6:0] own,
                                       input logic busy);
    return addr_hit(byte_v, own) && !busy;
  endfunction

endpackage

// File: rtl/i2c_line_sync.sv
`timescale 1ns/1ps
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic level_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int DEPTH = STAGES + 1;

  logic [DEPTH-1:0] pipe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '1;
    else        pipe_q <= {pipe_q[DEPTH-2:0], line_i};
  end

  assign level_o = pipe_q[STAGES-1];
  assign rise_o  = pipe_q[STAGES-1] & ~pipe_q[STAGES];
  assign fall_o  = ~pipe_q[STAGES-1] & pipe_q[STAGES];
endmodule

// File: rtl/i2c_bus_cond.sv
`timescale 1ns/1ps
module i2c_bus_cond (
  input  logic scl_level_i,
  input  logic sda_rise_i,
  input  logic sda_fall_i,
  output logic start_o,
  output logic stop_o
);
  // Data edges while the clock line is high are bus conditions
  assign start_o = scl_level_i & sda_fall_i;
  assign stop_o  = scl_level_i & sda_rise_i;
endmodule

// File: rtl/i2c_shift_reg.sv
`timescale 1ns/1ps
module i2c_shift_reg #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [WIDTH-1:0] load_val_i,
  input  logic             shift_i,
  input  logic             bit_i,
  output logic [WIDTH-1:0] q_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       q_o <= '0;
    else if (load_i)  q_o <= load_val_i;
    else if (shift_i) q_o <= {q_o[WIDTH-2:0], bit_i};
  end
endmodule

// File: rtl/i2c_cond_ack_target.sv
`timescale 1ns/1ps
module i2c_cond_ack_target
  import i2c_tgt_pkg::*;
#(
  parameter logic [6:0] OWN_ADDR    = 7'h2A,
  parameter int         SYNC_STAGES = 2,
  parameter int         BYTE_W      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  input  logic              busy_i,
  input  logic              rx_full_i,
  output logic              rx_valid_o,
  output logic [BYTE_W-1:0] rx_data_o,
  output logic              tx_req_o,
  input  logic [BYTE_W-1:0] tx_data_i
);
  localparam int CNT_W   = $clog2(BYTE_W + 1);
  localparam int N_LINES = 2;
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);

  // ---------------- line synchronisers (index 0 = SCL, 1 = SDA)
  logic [N_LINES-1:0] raw_lines, lvl, rise, fall;
  assign raw_lines = {sda_i, scl_i};

  for (genvar g = 0; g < N_LINES; g++) begin : g_sync
    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .line_i (raw_lines[g]),
      .level_o(lvl[g]),
      .rise_o (rise[g]),
      .fall_o (fall[g])
    );
  end

  // Named internal events for the assertions
  logic scl_s, sda_s, scl_rise, scl_fall, start_evt, stop_evt;
  assign scl_s    = lvl[0];
  assign sda_s    = lvl[1];
  assign scl_rise = rise[0];
  assign scl_fall = fall[0];

  i2c_bus_cond u_cond (
    .scl_level_i(scl_s),
    .sda_rise_i (rise[1]),
    .sda_fall_i (fall[1]),
    .start_o    (start_evt),
    .stop_o     (stop_evt)
  );

  // ---------------- state
  tgt_state_e        state_q;
  logic [CNT_W-1:0]  bit_cnt_q;
  logic              rw_q, tx_acked_q, oe_q, rx_valid_q, tx_req_q;
  logic [BYTE_W-1:0] rx_data_q;

  // ---------------- shift register control
  logic              sh_load, sh_shift, sh_bit;
  logic [BYTE_W-1:0] sh_q;

  always_comb begin
    sh_load  = 1'b0;
    sh_shift = 1'b0;
    sh_bit   = 1'b1;
    if (!start_evt && !stop_evt) begin
      if (scl_rise && (state_q == ST_ADDR || state_q == ST_RX) && bit_cnt_q != LAST_BIT) begin
        sh_shift = 1'b1;
        sh_bit   = sda_s;
      end
      if (scl_fall && state_q == ST_TX && bit_cnt_q != LAST_BIT) sh_shift = 1'b1;
      if (scl_fall && ((state_q == ST_ADDR_ACK && rw_q) || (state_q == ST_TX_ACK && tx_acked_q)))
        sh_load = 1'b1;
    end
  end

  i2c_shift_reg #(.WIDTH(BYTE_W)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_i    (sh_load),
    .load_val_i(tx_data_i),
    .shift_i   (sh_shift),
    .bit_i     (sh_bit),
    .q_o       (sh_q)
  );

  // ---------------- protocol state machine
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      bit_cnt_q  <= '0;
      rw_q       <= 1'b0;
      tx_acked_q <= 1'b0;
      oe_q       <= 1'b0;
      rx_valid_q <= 1'b0;
      rx_data_q  <= '0;
      tx_req_q   <= 1'b0;
    end else begin
      rx_valid_q <= 1'b0;
      tx_req_q   <= 1'b0;
      if (start_evt) begin
        state_q    <= ST_ADDR;
        bit_cnt_q  <= '0;
        oe_q       <= 1'b0;
        tx_acked_q <= 1'b0;
      end else if (stop_evt) begin
        state_q    <= ST_IDLE;
        bit_cnt_q  <= '0;
        oe_q       <= 1'b0;
        tx_acked_q <= 1'b0;
      end else begin
        case (state_q)
          ST_ADDR: begin
            if (scl_rise && bit_cnt_q != LAST_BIT) bit_cnt_q <= bit_cnt_q + 1'b1;
            if (scl_fall && bit_cnt_q == LAST_BIT) begin
              if (addr_accept(sh_q, OWN_ADDR, busy_i)) begin
                oe_q     <= 1'b1;
                rw_q     <= sh_q[0];
                tx_req_q <= sh_q[0];
                state_q  <= ST_ADDR_ACK;
              end else begin
                state_q  <= ST_HOLD_OFF;
              end
            end
          end
          ST_ADDR_ACK: begin
            if (scl_fall) begin
              bit_cnt_q  <= '0;
              tx_acked_q <= 1'b0;
              if (rw_q) begin
                oe_q    <= ~tx_data_i[BYTE_W-1];
                state_q <= ST_TX;
              end else begin
                oe_q    <= 1'b0;
                state_q <= ST_RX;
              end
            end
          end
          ST_RX: begin
            if (scl_rise && bit_cnt_q != LAST_BIT) bit_cnt_q <= bit_cnt_q + 1'b1;
            if (scl_fall && bit_cnt_q == LAST_BIT) begin
              if (!rx_full_i) begin
                oe_q       <= 1'b1;
                rx_valid_q <= 1'b1;
                rx_data_q  <= sh_q;
                state_q    <= ST_RX_ACK;
              end else begin
                state_q    <= ST_HOLD_OFF;
              end
            end
          end
          ST_RX_ACK: begin
            if (scl_fall) begin
              oe_q      <= 1'b0;
              bit_cnt_q <= '0;
              state_q   <= ST_RX;
            end
          end
          ST_TX: begin
            if (scl_rise && bit_cnt_q != LAST_BIT) bit_cnt_q <= bit_cnt_q + 1'b1;
            if (scl_fall) begin
              if (bit_cnt_q == LAST_BIT) begin
                oe_q       <= 1'b0;
                tx_acked_q <= 1'b0;
                state_q    <= ST_TX_ACK;
              end else begin
                oe_q <= ~sh_q[BYTE_W-2];
              end
            end
          end
          ST_TX_ACK: begin
            if (scl_rise) begin
              if (!sda_s) begin
                tx_acked_q <= 1'b1;
                tx_req_q   <= 1'b1;
              end else begin
                state_q    <= ST_HOLD_OFF;
              end
            end
            if (scl_fall && tx_acked_q) begin
              oe_q       <= ~tx_data_i[BYTE_W-1];
              bit_cnt_q  <= '0;
              tx_acked_q <= 1'b0;
              state_q    <= ST_TX;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_oe_o   = oe_q;
  assign rx_valid_o = rx_valid_q;
  assign rx_data_o  = rx_data_q;
  assign tx_req_o   = tx_req_q;

  // ---------------- assertions
  a_r1_ack_held_high_phase: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_ADDR_ACK || state_q == ST_RX_ACK) && scl_s) |-> sda_oe_o);

  a_r2_busy_refuses_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_fall && state_q == ST_ADDR && bit_cnt_q == LAST_BIT && busy_i) |=>
      (!sda_oe_o && !tx_req_o && state_q == ST_HOLD_OFF));

  a_r4_rx_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid_o |=> !rx_valid_o);

  a_r5_full_refuses_byte: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_fall && state_q == ST_RX && bit_cnt_q == LAST_BIT && rx_full_i && !start_evt && !stop_evt) |=>
      (!sda_oe_o && !rx_valid_o));

  a_r7_tx_ack_released: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_TX_ACK && !(scl_fall && tx_acked_q)) |-> !sda_oe_o);

  a_r8_holdoff_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_HOLD_OFF) |-> (!sda_oe_o && !tx_req_o && !rx_valid_o));

  a_r9_restart_to_addr: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> (state_q == ST_ADDR && bit_cnt_q == '0 && !sda_oe_o));

  a_r10_oe_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe_o) |-> !scl_s);

endmodule

// File: tb/i2c_cond_ack_target_tb.sv
`timescale 1ns/1ps
module i2c_cond_ack_target_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int QTR  = 8;
  localparam int HIGH = 20;
  localparam logic [6:0] DEV = 7'h2A;
  localparam int WATCHDOG = 190000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic busy = 1'b0, full = 1'b0;
  logic sda_oe, rx_valid, tx_req;
  logic [7:0] rx_data;
  logic [7:0] tx_data = 8'h00;
  wire  sda_bus = sda_m & ~sda_oe;

  int n_cmp = 0, n_mis = 0;
  int rx_cnt = 0, req_cnt = 0;
  logic [7:0] rx_log [0:255];
  logic [7:0] tx_bytes [0:255];
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_cond_ack_target #(.OWN_ADDR(DEV)) dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe_o(sda_oe),
    .busy_i(busy), .rx_full_i(full), .rx_valid_o(rx_valid), .rx_data_o(rx_data),
    .tx_req_o(tx_req), .tx_data_i(tx_data)
  );

  // Monitors sample away from the active edge
  always @(negedge clk) begin
    if (rst_n && rx_valid) begin
      rx_log[rx_cnt[7:0]] = rx_data;
      rx_cnt = rx_cnt + 1;
    end
    if (rst_n && tx_req) begin
      tx_data = tx_bytes[req_cnt[7:0]];
      req_cnt = req_cnt + 1;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_mis++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic exp_addr_ack(input logic [7:0] b, input logic bsy);
    return (b[7:1] == DEV) && (bsy == 1'b0);
  endfunction

  task automatic wclk(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic put_bit(input logic b);
    sda_m = b; wclk(QTR);
    scl_m = 1'b1; wclk(HIGH);
    scl_m = 1'b0; wclk(QTR);
  endtask

  task automatic do_start;
    sda_m = 1'b1; scl_m = 1'b1; wclk(QTR);
    sda_m = 1'b0; wclk(QTR);
    scl_m = 1'b0; wclk(QTR);
  endtask

  task automatic do_rstart;
    sda_m = 1'b1; wclk(QTR);
    scl_m = 1'b1; wclk(QTR);
    sda_m = 1'b0; wclk(QTR);
    scl_m = 1'b0; wclk(QTR);
  endtask

  task automatic do_stop;
    sda_m = 1'b0; wclk(QTR);
    scl_m = 1'b1; wclk(QTR);
    sda_m = 1'b1; wclk(QTR);
  endtask

  // Sends a byte and returns 1 when SDA stayed low across the whole ninth high phase
  task automatic send_byte(input logic [7:0] b, output logic acked);
    logic l0, l1, l2;
    for (int i = 7; i >= 0; i--) put_bit(b[i]);
    sda_m = 1'b1; wclk(QTR);
    scl_m = 1'b1; wclk(2);
    l0 = sda_bus; wclk(HIGH/2 - 2);
    l1 = sda_bus; wclk(HIGH/2 - 1);
    l2 = sda_bus; wclk(1);
    scl_m = 1'b0; wclk(QTR);
    acked = !l0 && !l1 && !l2;
  endtask

  task automatic recv_bits(output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wclk(QTR);
      scl_m = 1'b1; wclk(HIGH/2);
      b[i] = sda_bus; wclk(HIGH/2);
      scl_m = 1'b0; wclk(QTR);
    end
  endtask

  // One random transaction checked against bench-side expectations
  task automatic random_txn;
    logic [7:0] abyte, d, got;
    logic ack, exp_a, rw, refused;
    int nbytes, full_at, req0, rx0;
    rw = $urandom_range(0, 1);
    if ($urandom_range(0, 3) != 0) abyte = {DEV, rw};
    else abyte = {DEV ^ 7'($urandom_range(1, 127)), rw};
    busy    = ($urandom_range(0, 3) == 0);
    nbytes  = $urandom_range(1, 4);
    full_at = $urandom_range(0, 5);
    exp_a   = exp_addr_ack(abyte, busy);
    req0    = req_cnt;
    do_start;
    send_byte(abyte, ack);
    chk(exp_a ? "R1 random address ack" : (busy ? "R2 random busy nack" : "R3 random foreign nack"),
        32'(ack), 32'(exp_a));
    busy = 1'b0;
    if (!rw) begin
      refused = !exp_a;
      for (int i = 0; i < nbytes; i++) begin
        full = (i >= full_at);
        d = 8'($urandom);
        rx0 = rx_cnt;
        send_byte(d, ack);
        chk("R4/R5 random data ack", 32'(ack), 32'(!refused && !full));
        chk("R4/R5 random delivery count", 32'(rx_cnt - rx0), 32'(!refused && !full));
        if (!refused && !full) chk("R4 random data value", 32'(rx_log[rx0[7:0]]), 32'(d));
        if (full) refused = 1'b1;
      end
      full = 1'b0;
    end else if (exp_a) begin
      for (int i = 0; i < nbytes; i++) begin
        recv_bits(got);
        chk("R6/R7 random read byte", 32'(got), 32'(tx_bytes[8'(req_cnt - 1)]));
        put_bit(i == nbytes - 1);
      end
      chk("R7 random request count", 32'(req_cnt - req0), 32'(nbytes));
    end else begin
      recv_bits(got);
      put_bit(1'b1);
      chk("R3 random refused read idle", 32'(got), 32'hFF);
      chk("R3 random no request", 32'(req_cnt - req0), 32'd0);
    end
    do_stop;
  endtask

  initial begin : main
    logic ack;
    logic [7:0] got;
    int r0, q0;
    void'($urandom(32'd4242));
    for (int i = 0; i < 256; i++) tx_bytes[i] = 8'($urandom);
    tx_bytes[0] = 8'hA5;
    tx_bytes[1] = 8'h3C;
    #(CLK_PERIOD * 3);
    chk("R11 oe after reset", 32'(sda_oe), 32'd0);
    chk("R11 rx_valid after reset", 32'(rx_valid), 32'd0);
    chk("R11 tx_req after reset", 32'(tx_req), 32'd0);
    rst_n = 1'b1;
    wclk(10);

    // Directed write with two accepted bytes
    do_start;
    send_byte({DEV, 1'b0}, ack);
    chk("R1 own address acked", 32'(ack), 32'd1);
    r0 = rx_cnt;
    send_byte(8'h81, ack);
    chk("R4 byte 0 acked", 32'(ack), 32'd1);
    send_byte(8'h7E, ack);
    chk("R4 byte 1 acked", 32'(ack), 32'd1);
    chk("R4 two pulses", 32'(rx_cnt - r0), 32'd2);
    chk("R4 byte 0 value", 32'(rx_log[r0[7:0]]), 32'h81);
    chk("R4 byte 1 value", 32'(rx_log[8'(r0 + 1)]), 32'h7E);
    // Full on the third byte: refused, and the next byte too
    full = 1'b1;
    send_byte(8'h55, ack);
    chk("R5 full byte nacked", 32'(ack), 32'd0);
    full = 1'b0;
    send_byte(8'h66, ack);
    chk("R5 later byte nacked", 32'(ack), 32'd0);
    chk("R5 nothing delivered", 32'(rx_cnt - r0), 32'd2);
    do_stop;

    // Busy refuses the address; repeated start after hold-off recovers
    busy = 1'b1;
    do_start;
    send_byte({DEV, 1'b0}, ack);
    chk("R2 busy address nacked", 32'(ack), 32'd0);
    busy = 1'b0;
    r0 = rx_cnt;
    send_byte(8'h12, ack);
    chk("R2 data after busy nacked", 32'(ack), 32'd0);
    chk("R2 no delivery", 32'(rx_cnt - r0), 32'd0);
    do_rstart;
    send_byte({DEV, 1'b0}, ack);
    chk("R9 restart from hold-off acked", 32'(ack), 32'd1);
    // Repeated start in the middle of a data byte
    for (int i = 0; i < 4; i++) put_bit(1'b1);
    do_rstart;
    send_byte({DEV, 1'b0}, ack);
    chk("R9 restart mid-byte address acked", 32'(ack), 32'd1);
    send_byte(8'hC3, ack);
    chk("R9 byte after restart acked", 32'(ack), 32'd1);
    chk("R9 byte after restart value", 32'(rx_log[8'(rx_cnt - 1)]), 32'hC3);
    do_stop;

    // Foreign address
    do_start;
    send_byte({DEV ^ 7'h01, 1'b0}, ack);
    chk("R3 foreign address nacked", 32'(ack), 32'd0);
    send_byte(8'h00, ack);
    chk("R3 data after foreign nacked", 32'(ack), 32'd0);
    do_stop;

    // Read: two bytes, master ACK then NACK, then extra clocks with no stop
    q0 = req_cnt;
    do_start;
    send_byte({DEV, 1'b1}, ack);
    chk("R6 read address acked", 32'(ack), 32'd1);
    chk("R6 one request", 32'(req_cnt - q0), 32'd1);
    recv_bits(got);
    chk("R6 first byte msb first", 32'(got), 32'hA5);
    put_bit(1'b0);
    chk("R7 request after master ack", 32'(req_cnt - q0), 32'd2);
    recv_bits(got);
    chk("R7 second byte", 32'(got), 32'h3C);
    put_bit(1'b1);
    recv_bits(got);
    chk("R8 released after master nack", 32'(got), 32'hFF);
    chk("R8 no request after nack", 32'(req_cnt - q0), 32'd2);
    chk("R10 line released", 32'(sda_oe), 32'd0);
    do_stop;

    for (int t = 0; t < 24; t++) random_txn;

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
    $finish;
  end

  initial begin : watchdog
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_mis++;
      $display("FAIL watchdog expired actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
      $finish;
    end
  end
endmodule